// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, in one clock, where an issuing load gets its data. It looks at the stores held in a circular store queue, starting with the youngest store older than the load and moving toward the oldest one. It compares byte ranges and picks one outcome:

- **Forward:** return store data aligned to the load.
- **Stall:** a store that has not completed covers only part of the load, so the load must be replayed.
- **Cache access:** send the load on to the data cache.
- **Reschedule:** the load is uncacheable and is not yet allowed to go.

The block also keeps two records. The stall record belongs to the oldest load that stalled on a partial overlap. The blocked record holds the sequence number of the oldest load that found the cache blocked.

The store queue is read combinationally from the owning queue, so all of its entries are visible at once. The result is registered. A load presented in one cycle has its outcome on the result port in the next cycle, and both records update on that same edge.

Top module: `stlf_checker`

## Requirements
- R1: Every accepted load (`ld_valid_i` high at a rising edge) produces `res_valid_o` high for exactly the following cycle. `res_kind_o` is one-hot in that cycle: bit0 forward, bit1 stall, bit2 cache access, bit3 uncached reschedule. With no load accepted, `res_valid_o` is low.
- R2: An uncacheable load reports reschedule (bit3) unless its load-queue index equals `lq_head_i` and `ld_at_commit_i` is high. When both hold, it is checked like any other load.
- R3: The scan visits store indices `ld_sq_idx_i`, then `ld_sq_idx_i-1`, and so on. Below index 0 it wraps to `SQ_DEPTH-1`. It stops after `sq_head_i`, so entries older than the head are never considered. The first entry that decides wins, and `res_sq_idx_o` gives its index.
- R4: Entries that are not valid, have size zero, or are marked uncacheable are skipped.
- R5: A store fully covers a load when `store_addr <= load_addr` and `load_addr + load_size <= store_addr + store_size`. Such a store forwards even if it has completed. `res_data_o` is the store data shifted right by `8*(load_addr & (store_size-1))` bits, with bytes at or above `load_size` cleared.
- R6: A load whose range intersects a store's range without being fully covered by it, where that store has not completed, reports stall. `res_data_o` is zero for every outcome except forward.
- R7: A partial overlap with a completed store is ignored, and the scan goes on to older entries.
- R8: On a stall, the record (`stall_pend_o`, `stall_st_seq_o` = the sequence number of the stalling store, `stall_lq_idx_o`) is written only if no stall is pending or the load's sequence number is smaller than that of the recorded load.
- R9: A load that reaches no deciding entry reports cache access.
- R10: A cache-access load with `cache_blocked_i` high sets `blk_pend_o` and `blk_seq_o` to its sequence number. It does not do so when a blocked load with a smaller sequence number is already recorded. Loads with any other outcome never change the blocked record.
- R11: Ranges that only touch, with the load ending exactly at the store's start, do not overlap and have no effect on the outcome.
- R12: After reset, `res_valid_o`, `stall_pend_o` and `blk_pend_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load request presented |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | SIZE_W | Load size in bytes |
| ld_uncached_i | input | 1 | Load is uncacheable |
| ld_at_commit_i | input | 1 | Load is ready to commit |
| ld_lq_idx_i | input | LQ_IDX_W | Load-queue index of the load |
| ld_sq_idx_i | input | SQ_IDX_W | Youngest store index older than the load |
| ld_seq_i | input | SEQ_W | Load sequence number |
| lq_head_i | input | LQ_IDX_W | Load-queue head index |
| sq_head_i | input | SQ_IDX_W | Store-queue head (oldest) index |
| sq_valid_i | input | SQ_DEPTH | Per-entry valid |
| sq_addr_i | input | SQ_DEPTH x ADDR_W | Per-entry store address |
| sq_size_i | input | SQ_DEPTH x SIZE_W | Per-entry store size (power of two, or zero) |
| sq_uncached_i | input | SQ_DEPTH | Per-entry uncacheable flag |
| sq_done_i | input | SQ_DEPTH | Per-entry completed flag |
| sq_seq_i | input | SQ_DEPTH x SEQ_W | Per-entry store sequence number |
| sq_data_i | input | SQ_DEPTH x DATA_W | Per-entry store data |
| cache_blocked_i | input | 1 | Data cache reports blocked |
| res_valid_o | output | 1 | Result valid |
| res_kind_o | output | 4 | One-hot outcome |
| res_sq_idx_o | output | SQ_IDX_W | Deciding store index (forward or stall), else 0 |
| res_data_o | output | DATA_W | Forwarded data |
| stall_pend_o | output | 1 | Stall record valid |
| stall_st_seq_o | output | SEQ_W | Stalling store sequence number |
| stall_lq_idx_o | output | LQ_IDX_W | Load-queue index of the recorded stalled load |
| blk_pend_o | output | 1 | Blocked record valid |
| blk_seq_o | output | SEQ_W | Sequence number of the recorded blocked load |

## Verification
Some rules are checked on every cycle:
- the result follows a request by exactly one cycle and is one-hot;
- a reschedule traces back to an uncacheable request;
- either record changes only in the cycle that reports the matching outcome;
- neither recorded sequence number grows while its record stays pending.

Other behaviour only the bench's scenarios can show, because it depends on the contents of the store queue:
- which entry wins the scan, including the wrap below index zero and the stop at the head;
- which entries are skipped;
- how completed partial overlaps are handled;
- the shift and mask of the forwarded data;
- the head and commit gate for uncacheable loads.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  localparam int KIND_W = 4;
  localparam logic [KIND_W-1:0] KIND_FWD     = 4'b0001;
  localparam logic [KIND_W-1:0] KIND_STALL   = 4'b0010;
  localparam logic [KIND_W-1:0] KIND_CACHE   = 4'b0100;
  localparam logic [KIND_W-1:0] KIND_RESCHED = 4'b1000;
endpackage

// File: rtl/stlf_range_cmp.sv
module stlf_range_cmp #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              st_valid_i,
  input  logic              st_uncached_i,
  input  logic              st_done_i,
  input  logic              in_range_i,
  output logic              stop_o,
  output logic              full_o
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic          eligible, covers, overlaps;

  always_comb begin
    ld_lo    = {1'b0, ld_addr_i};
    ld_hi    = ld_lo + {{(EW-SIZE_W){1'b0}}, ld_size_i};
    st_lo    = {1'b0, st_addr_i};
    st_hi    = st_lo + {{(EW-SIZE_W){1'b0}}, st_size_i};
    eligible = in_range_i && st_valid_i && (st_size_i != '0) && !st_uncached_i;
    covers   = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    overlaps = (ld_lo < st_hi) && (ld_hi > st_lo);
    // completed partial overlaps fall through to older entries
    stop_o   = eligible && (covers || (overlaps && !st_done_i));
    full_o   = eligible && covers;
  end
endmodule

// File: rtl/stlf_scan_sel.sv
module stlf_scan_sel #(
  parameter int SQ_DEPTH = 8,
  localparam int IDX_W = $clog2(SQ_DEPTH)
) (
  input  logic [SQ_DEPTH-1:0] stop_i,
  input  logic [SQ_DEPTH-1:0] full_i,
  output logic                hit_o,
  output logic                hit_full_o,
  output logic [IDX_W-1:0]    hit_step_o
);
  // step 0 is the youngest older store
  always_comb begin
    hit_o      = 1'b0;
    hit_full_o = 1'b0;
    hit_step_o = '0;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      if (!hit_o && stop_i[k]) begin
        hit_o      = 1'b1;
        hit_full_o = full_i[k];
        hit_step_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/stlf_fwd_data.sv
module stlf_fwd_data #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NBYTES = DATA_W / 8;
  localparam int SH_W   = SIZE_W + 3;

  logic [SIZE_W-1:0] offset;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    offset  = ld_addr_i[SIZE_W-1:0] & (st_size_i - SIZE_W'(1));
    shamt   = {offset, 3'b000};
    shifted = st_data_i >> shamt;
    for (int b = 0; b < NBYTES; b++) begin
      data_o[b*8 +: 8] = (int'(ld_size_i) > b) ? shifted[b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/stlf_rec_track.sv
module stlf_rec_track #(
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stall_req_i,
  input  logic                blk_req_i,
  input  logic [SEQ_W-1:0]    ld_seq_i,
  input  logic [LQ_IDX_W-1:0] ld_lq_idx_i,
  input  logic [SEQ_W-1:0]    st_seq_i,
  output logic                stall_pend_o,
  output logic [SEQ_W-1:0]    stall_st_seq_o,
  output logic [LQ_IDX_W-1:0] stall_lq_idx_o,
  output logic                blk_pend_o,
  output logic [SEQ_W-1:0]    blk_seq_o
);
  logic [SEQ_W-1:0] stall_ld_seq_q;
  logic             stall_take, blk_take;

  assign stall_take = stall_req_i && (!stall_pend_o || (ld_seq_i < stall_ld_seq_q));
  assign blk_take   = blk_req_i && !(blk_pend_o && (blk_seq_o < ld_seq_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_pend_o   <= 1'b0;
      stall_st_seq_o <= '0;
      stall_lq_idx_o <= '0;
      stall_ld_seq_q <= '0;
      blk_pend_o     <= 1'b0;
      blk_seq_o      <= '0;
    end else begin
      if (stall_take) begin
        stall_pend_o   <= 1'b1;
        stall_st_seq_o <= st_seq_i;
        stall_lq_idx_o <= ld_lq_idx_i;
        stall_ld_seq_q <= ld_seq_i;
      end
      if (blk_take) begin
        blk_pend_o <= 1'b1;
        blk_seq_o  <= ld_seq_i;
      end
    end
  end

  // R8
  stall_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stall_pend_o) |-> stall_pend_o);
  // R8
  stall_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_pend_o && $past(stall_pend_o)) |-> (stall_ld_seq_q <= $past(stall_ld_seq_q)));
  // R10
  blk_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_pend_o && $past(blk_pend_o)) |-> (blk_seq_o <= $past(blk_seq_o)));
endmodule

// File: rtl/stlf_checker.sv
module stlf_checker
  import stlf_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 16,
  parameter int SIZE_W   = 4,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16,
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH),
  localparam int LQ_IDX_W = $clog2(LQ_DEPTH)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               ld_valid_i,
  input  logic [ADDR_W-1:0]                  ld_addr_i,
  input  logic [SIZE_W-1:0]                  ld_size_i,
  input  logic                               ld_uncached_i,
  input  logic                               ld_at_commit_i,
  input  logic [LQ_IDX_W-1:0]                ld_lq_idx_i,
  input  logic [SQ_IDX_W-1:0]                ld_sq_idx_i,
  input  logic [SEQ_W-1:0]                   ld_seq_i,
  input  logic [LQ_IDX_W-1:0]                lq_head_i,
  input  logic [SQ_IDX_W-1:0]                sq_head_i,
  input  logic [SQ_DEPTH-1:0]                sq_valid_i,
  input  logic [SQ_DEPTH-1:0][ADDR_W-1:0]    sq_addr_i,
  input  logic [SQ_DEPTH-1:0][SIZE_W-1:0]    sq_size_i,
  input  logic [SQ_DEPTH-1:0]                sq_uncached_i,
  input  logic [SQ_DEPTH-1:0]                sq_done_i,
  input  logic [SQ_DEPTH-1:0][SEQ_W-1:0]     sq_seq_i,
  input  logic [SQ_DEPTH-1:0][DATA_W-1:0]    sq_data_i,
  input  logic                               cache_blocked_i,
  output logic                               res_valid_o,
  output logic [KIND_W-1:0]                  res_kind_o,
  output logic [SQ_IDX_W-1:0]                res_sq_idx_o,
  output logic [DATA_W-1:0]                  res_data_o,
  output logic                               stall_pend_o,
  output logic [SEQ_W-1:0]                   stall_st_seq_o,
  output logic [LQ_IDX_W-1:0]                stall_lq_idx_o,
  output logic                               blk_pend_o,
  output logic [SEQ_W-1:0]                   blk_seq_o
);
  localparam int CW = SQ_IDX_W + 1;
  localparam logic [CW-1:0] DEPTH_V = CW'(SQ_DEPTH);

  logic [CW-1:0]       start_ext, head_ext, span;
  logic [SQ_IDX_W-1:0] scan_idx [SQ_DEPTH];
  logic [SQ_DEPTH-1:0] stop_v, full_v;

  assign start_ext = {1'b0, ld_sq_idx_i};
  assign head_ext  = {1'b0, sq_head_i};
  // entries from the start index back to the head, inclusive
  assign span = (start_ext >= head_ext) ? (start_ext - head_ext)
                                        : (start_ext + DEPTH_V - head_ext);

  for (genvar k = 0; k < SQ_DEPTH; k++) begin : g_step
    localparam logic [CW-1:0] STEP = CW'(k);
    logic [CW-1:0] wrapped;
    assign wrapped     = (start_ext >= STEP) ? (start_ext - STEP) : (start_ext + DEPTH_V - STEP);
    assign scan_idx[k] = wrapped[SQ_IDX_W-1:0];

    stlf_range_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
      .ld_addr_i     (ld_addr_i),
      .ld_size_i     (ld_size_i),
      .st_addr_i     (sq_addr_i[scan_idx[k]]),
      .st_size_i     (sq_size_i[scan_idx[k]]),
      .st_valid_i    (sq_valid_i[scan_idx[k]]),
      .st_uncached_i (sq_uncached_i[scan_idx[k]]),
      .st_done_i     (sq_done_i[scan_idx[k]]),
      .in_range_i    (STEP <= span),
      .stop_o        (stop_v[k]),
      .full_o        (full_v[k])
    );
  end

  logic                hit, hit_full;
  logic [SQ_IDX_W-1:0] hit_step, hit_idx;

  stlf_scan_sel #(.SQ_DEPTH(SQ_DEPTH)) u_sel (
    .stop_i     (stop_v),
    .full_i     (full_v),
    .hit_o      (hit),
    .hit_full_o (hit_full),
    .hit_step_o (hit_step)
  );

  assign hit_idx = scan_idx[hit_step];

  logic [DATA_W-1:0] fwd_data;

  stlf_fwd_data #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_fwd (
    .st_data_i (sq_data_i[hit_idx]),
    .st_size_i (sq_size_i[hit_idx]),
    .ld_addr_i (ld_addr_i),
    .ld_size_i (ld_size_i),
    .data_o    (fwd_data)
  );

  logic              unc_hold;
  logic [KIND_W-1:0] kind_d;

  assign unc_hold = ld_uncached_i && ((ld_lq_idx_i != lq_head_i) || !ld_at_commit_i);

  always_comb begin
    if (unc_hold)      kind_d = KIND_RESCHED;
    else if (!hit)     kind_d = KIND_CACHE;
    else if (hit_full) kind_d = KIND_FWD;
    else               kind_d = KIND_STALL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_kind_o   <= '0;
      res_sq_idx_o <= '0;
      res_data_o   <= '0;
    end else begin
      res_valid_o  <= ld_valid_i;
      res_kind_o   <= ld_valid_i ? kind_d : '0;
      res_sq_idx_o <= (ld_valid_i && !unc_hold && hit) ? hit_idx : '0;
      res_data_o   <= (ld_valid_i && (kind_d == KIND_FWD)) ? fwd_data : '0;
    end
  end

  stlf_rec_track #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) u_rec (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stall_req_i    (ld_valid_i && (kind_d == KIND_STALL)),
    .blk_req_i      (ld_valid_i && (kind_d == KIND_CACHE) && cache_blocked_i),
    .ld_seq_i       (ld_seq_i),
    .ld_lq_idx_i    (ld_lq_idx_i),
    .st_seq_i       (sq_seq_i[hit_idx]),
    .stall_pend_o   (stall_pend_o),
    .stall_st_seq_o (stall_st_seq_o),
    .stall_lq_idx_o (stall_lq_idx_o),
    .blk_pend_o     (blk_pend_o),
    .blk_seq_o      (blk_seq_o)
  );

  // R1
  res_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> res_valid_o);
  // R1
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> !res_valid_o);
  // R1
  res_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($countones(res_kind_o) == 1));
  // R2
  resched_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o[3]) |-> $past(ld_uncached_i));
  // R8
  stall_rec_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stall_st_seq_o) |-> (res_valid_o && res_kind_o[1]));
  // R10
  blk_rec_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(blk_seq_o) |-> (res_valid_o && res_kind_o[2]));
  // R6
  data_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_kind_o[0]) |-> (res_data_o == '0));
endmodule

// File: tb/stlf_checker_tb.sv
`timescale 1ns/1ps
module stlf_checker_tb;
  localparam int D = 8;
  localparam logic [3:0] K_FWD = 4'b0001, K_STL = 4'b0010, K_CAC = 4'b0100, K_RES = 4'b1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic ld_valid, ld_unc, ld_cmt, cache_blk;
  logic [15:0] ld_addr, ld_seq;
  logic [3:0] ld_size;
  logic [2:0] ld_lq, ld_sq, lq_head, sq_head;
  logic [D-1:0] sq_valid, sq_unc, sq_done;
  logic [D-1:0][15:0] sq_addr, sq_seq;
  logic [D-1:0][3:0] sq_size;
  logic [D-1:0][63:0] sq_data;
  logic res_valid, stall_pend, blk_pend;
  logic [3:0] res_kind;
  logic [2:0] res_idx, stall_lq;
  logic [63:0] res_data;
  logic [15:0] stall_sseq, blk_seq;

  stlf_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_size_i(ld_size), .ld_uncached_i(ld_unc), .ld_at_commit_i(ld_cmt),
    .ld_lq_idx_i(ld_lq), .ld_sq_idx_i(ld_sq), .ld_seq_i(ld_seq),
    .lq_head_i(lq_head), .sq_head_i(sq_head), .sq_valid_i(sq_valid),
    .sq_addr_i(sq_addr), .sq_size_i(sq_size), .sq_uncached_i(sq_unc),
    .sq_done_i(sq_done), .sq_seq_i(sq_seq), .sq_data_i(sq_data),
    .cache_blocked_i(cache_blk), .res_valid_o(res_valid), .res_kind_o(res_kind),
    .res_sq_idx_o(res_idx), .res_data_o(res_data), .stall_pend_o(stall_pend),
    .stall_st_seq_o(stall_sseq), .stall_lq_idx_o(stall_lq),
    .blk_pend_o(blk_pend), .blk_seq_o(blk_seq)
  );

  typedef struct packed {
    logic [15:0] addr; logic [3:0] size; logic unc; logic cmt;
    logic [2:0] lq; logic [2:0] sq; logic [15:0] seq;
    logic [3:0] kind; logic [2:0] idx;
    logic spend; logic [2:0] slq; logic [15:0] sseq;
  } vec_t;

  localparam int NV = 14;
  // queue head 3; scan order checked per vector
  localparam vec_t VECS [NV] = '{
    '{16'h0102, 4'd2, 1'b0, 1'b0, 3'd1, 3'd2, 16'd10, K_FWD, 3'd3, 1'b0, 3'd0, 16'd0},   // R11 R4 R5
    '{16'h0104, 4'd4, 1'b0, 1'b0, 3'd5, 3'd2, 16'd50, K_STL, 3'd1, 1'b1, 3'd5, 16'd101}, // R6 R8
    '{16'h0202, 4'd4, 1'b0, 1'b0, 3'd1, 3'd1, 16'd11, K_CAC, 3'd0, 1'b1, 3'd5, 16'd101}, // R7 R9
    '{16'h0201, 4'd2, 1'b0, 1'b0, 3'd1, 3'd1, 16'd12, K_FWD, 3'd4, 1'b1, 3'd5, 16'd101}, // R5
    '{16'h0104, 4'd2, 1'b0, 1'b0, 3'd1, 3'd1, 16'd13, K_FWD, 3'd1, 1'b1, 3'd5, 16'd101}, // R3
    '{16'h0104, 4'd2, 1'b0, 1'b0, 3'd1, 3'd0, 16'd14, K_FWD, 3'd3, 1'b1, 3'd5, 16'd101}, // R3
    '{16'h0402, 4'd2, 1'b0, 1'b0, 3'd1, 3'd0, 16'd15, K_FWD, 3'd7, 1'b1, 3'd5, 16'd101}, // R3 wrap
    '{16'h0500, 4'd2, 1'b0, 1'b0, 3'd1, 3'd4, 16'd16, K_CAC, 3'd0, 1'b1, 3'd5, 16'd101}, // R3 head stop
    '{16'h0102, 4'd2, 1'b1, 1'b1, 3'd2, 3'd2, 16'd17, K_FWD, 3'd3, 1'b1, 3'd5, 16'd101}, // R2 allowed
    '{16'h0102, 4'd2, 1'b1, 1'b1, 3'd3, 3'd2, 16'd18, K_RES, 3'd0, 1'b1, 3'd5, 16'd101}, // R2 not head
    '{16'h0102, 4'd2, 1'b1, 1'b0, 3'd2, 3'd2, 16'd19, K_RES, 3'd0, 1'b1, 3'd5, 16'd101}, // R2 not commit
    '{16'h03FC, 4'd8, 1'b0, 1'b0, 3'd4, 3'd7, 16'd40, K_STL, 3'd7, 1'b1, 3'd4, 16'd107}, // R8 older
    '{16'h0104, 4'd4, 1'b0, 1'b0, 3'd6, 3'd2, 16'd60, K_STL, 3'd1, 1'b1, 3'd4, 16'd107}, // R8 younger
    '{16'h0300, 4'd2, 1'b0, 1'b0, 3'd1, 3'd5, 16'd70, K_CAC, 3'd0, 1'b1, 3'd4, 16'd107}  // R4 size zero
  };

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_fwd(input int i, input logic [15:0] a, input logic [3:0] ls);
    logic [3:0] off;
    logic [63:0] d;
    off = a[3:0] & (sq_size[i] - 4'd1);
    d = sq_data[i] >> (int'(off) * 8);
    for (int b = 0; b < 8; b++) if (b >= int'(ls)) d[b*8 +: 8] = 8'h00;
    return d;
  endfunction

  task automatic issue(input logic [15:0] a, input logic [3:0] s, input logic u, input logic c,
                       input logic [2:0] lq, input logic [2:0] sq, input logic [15:0] q);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_size = s; ld_unc = u; ld_cmt = c;
    ld_lq = lq; ld_sq = sq; ld_seq = q;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_addr = '0; ld_size = '0; ld_unc = 1'b0; ld_cmt = 1'b0;
    ld_lq = '0; ld_sq = '0; ld_seq = '0; cache_blk = 1'b0; lq_head = 3'd2; sq_head = 3'd3;
    sq_valid = '1; sq_unc = '0; sq_done = '0;
    for (int i = 0; i < D; i++) begin
      sq_seq[i] = 16'(100 + i);
      for (int b = 0; b < 8; b++) sq_data[i][b*8 +: 8] = 8'((i << 4) | b);
    end
    sq_addr[3] = 16'h0100; sq_size[3] = 4'd8;
    sq_addr[4] = 16'h0200; sq_size[4] = 4'd4; sq_done[4] = 1'b1;
    sq_addr[5] = 16'h0300; sq_size[5] = 4'd0;
    sq_addr[6] = 16'h0100; sq_size[6] = 4'd4; sq_unc[6] = 1'b1;
    sq_addr[7] = 16'h0400; sq_size[7] = 4'd8;
    sq_addr[0] = 16'h0500; sq_size[0] = 4'd2;
    sq_addr[1] = 16'h0104; sq_size[1] = 4'd2;
    sq_addr[2] = 16'h0600; sq_size[2] = 4'd8; sq_valid[2] = 1'b0;

    repeat (3) @(negedge clk);
    // R12
    check("R12 res_valid", 64'(res_valid), 64'd0);
    check("R12 stall_pend", 64'(stall_pend), 64'd0);
    check("R12 blk_pend", 64'(blk_pend), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 64'(res_valid), 64'd0);

    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].addr, VECS[v].size, VECS[v].unc, VECS[v].cmt, VECS[v].lq, VECS[v].sq, VECS[v].seq);
      check($sformatf("R1 valid v%0d", v), 64'(res_valid), 64'd1);
      check($sformatf("R3 kind v%0d", v), 64'(res_kind), 64'(VECS[v].kind));
      check($sformatf("R3 idx v%0d", v), 64'(res_idx), 64'(VECS[v].idx));
      if (VECS[v].kind == K_FWD)
        check($sformatf("R5 data v%0d", v), res_data,
              exp_fwd(int'(VECS[v].idx), VECS[v].addr, VECS[v].size));
      else
        check($sformatf("R6 data zero v%0d", v), res_data, 64'd0);
      check($sformatf("R8 pend v%0d", v), 64'(stall_pend), 64'(VECS[v].spend));
      check($sformatf("R8 lq v%0d", v), 64'(stall_lq), 64'(VECS[v].slq));
      check($sformatf("R8 sseq v%0d", v), 64'(stall_sseq), 64'(VECS[v].sseq));
      check($sformatf("R10 untouched v%0d", v), 64'(blk_pend), 64'd0);
    end
    @(negedge clk);
    check("R1 one cycle only", 64'(res_valid), 64'd0);

    // R10 blocked record
    cache_blk = 1'b1;
    issue(16'h0700, 4'd4, 1'b0, 1'b0, 3'd1, 3'd2, 16'd30);
    check("R10 kind", 64'(res_kind), 64'(K_CAC));
    check("R10 set pend", 64'(blk_pend), 64'd1);
    check("R10 set seq", 64'(blk_seq), 64'd30);
    issue(16'h0700, 4'd4, 1'b0, 1'b0, 3'd1, 3'd2, 16'd35);
    check("R10 younger kept", 64'(blk_seq), 64'd30);
    issue(16'h0700, 4'd4, 1'b0, 1'b0, 3'd1, 3'd2, 16'd20);
    check("R10 older taken", 64'(blk_seq), 64'd20);
    issue(16'h0102, 4'd2, 1'b0, 1'b0, 3'd1, 3'd2, 16'd5);
    check("R10 forward kind", 64'(res_kind), 64'(K_FWD));
    check("R10 forward no record", 64'(blk_seq), 64'd20);
    cache_blk = 1'b0;

    // R12 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 stall cleared", 64'(stall_pend), 64'd0);
    check("R12 blk cleared", 64'(blk_pend), 64'd0);
    rst_n = 1'b1;
    // R8 fresh record after reset
    issue(16'h0104, 4'd4, 1'b0, 1'b0, 3'd6, 3'd2, 16'd60);
    check("R8 after reset lq", 64'(stall_lq), 64'd6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule